// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block arbitrates among 60 maskable interrupt request lines. Each line has an enable bit and a priority byte. Only the upper nibble of that byte is stored. A global grouping value sets how many of the four stored bits form the preemption part; the remaining low bits form the sub-priority. A rising edge on a request line marks the line pending. Each cycle, a tree of comparators picks the best enabled pending line. The block then checks whether that line's preemption value beats the level of the handler now running.

When the winner beats the active level, the block issues a one-cycle take pulse with the 6-bit channel index. It clears that line's pending bit and pushes the new preemption value onto a level stack, which lets handlers nest. An end-of-handler strobe pops the stack and restores the previous level. Configuration goes through a small write port that selects a register kind and a channel, and a combinational read port reflects the same selection.

Top module: `grp_irq_arbiter`

## Requirements
- R1: After reset, take_o is low, act_lvl_o is 16 (thread level, below every handler), every priority and enable is zero and the grouping value is zero.
- R2: A priority write (cfg_sel_i = 0) keeps only bits 7:4 of the data; reading a priority returns those four bits in 7:4 and zero in 3:0.
- R3: The grouping register (cfg_sel_i = 2) holds the number of preemption bits, 0 to 4; a write of a value above 4 leaves it unchanged. A line's preemption value is its 4-bit priority shifted right by (4 - grouping).
- R4: A pending bit is set by a rising edge on its request line. A take pulse lasts one cycle, the taken line's pending bit is cleared at the same edge, and a line held high is not taken again.
- R5: A line whose enable (cfg_sel_i = 1, data bit 0) is zero never wins, but its pending bit is kept and it is taken once enabled.
- R6: Among enabled pending lines, the lowest preemption value wins, then the lowest sub-priority, then the lowest channel index.
- R7: The winner is taken only if its preemption value is strictly below act_lvl_o; an equal preemption value with a lower sub-priority does not preempt and waits.
- R8: On a take, act_lvl_o becomes the winner's preemption value and the earlier level is saved; eoi_i restores the saved level, no take is issued in a cycle with eoi_i high, and eoi_i at thread level has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 60 | Request lines, one per channel |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register kind: 0 priority, 1 enable, 2 grouping, 3 none |
| cfg_chan_i | input | 6 | Channel addressed by priority and enable accesses |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for the current selection |
| eoi_i | input | 1 | End-of-handler strobe |
| take_o | output | 1 | One-cycle take pulse |
| vec_o | output | 6 | Index of the taken channel, valid with take_o |
| act_lvl_o | output | 5 | Active preemption level, 16 at thread level |

## Verification
The assertions assume eoi_i is raised only for a handler that was actually taken, and that the grouping value is changed only at thread level. Otherwise a saved level would mix two encodings, and the level ordering checks would no longer hold. The stimulus changes grouping only right after a reset. It pairs each eoi_i with an earlier take, and it keeps a single spare end strobe to test the behaviour at thread level. Requests are raised and dropped between clock edges, and each raised line is held until its take has been observed.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_CH      = 60;
    localparam int PRIO_BITS   = 4;
    localparam int CFG_DW      = 8;
    localparam int IDX_W       = $clog2(NUM_CH);
    localparam int LVL_W       = PRIO_BITS + 1;
    localparam int GRP_W       = $clog2(PRIO_BITS + 1);
    localparam int THREAD_LVL  = 1 << PRIO_BITS;
    localparam int STACK_DEPTH = 1 << PRIO_BITS;
    localparam int LEAVES      = 1 << IDX_W;

    typedef enum logic [1:0] {
        SEL_PRIO  = 2'd0,
        SEL_EN    = 2'd1,
        SEL_GROUP = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic                 valid;
        logic [PRIO_BITS-1:0] prio;
        logic [IDX_W-1:0]     idx;
    } cand_t;

    // Preemption part of a stored priority under a given grouping
    function automatic logic [LVL_W-1:0] preempt_of(
        input logic [PRIO_BITS-1:0] p,
        input logic [GRP_W-1:0]     g
    );
        logic [LVL_W-1:0] wide;
        int               sh;
        wide = {1'b0, p};
        sh   = PRIO_BITS - int'(g);
        return wide >> sh;
    endfunction

    // Return the better of two candidates: value first, then index
    function automatic cand_t pick(input cand_t a, input cand_t b);
        if (!b.valid)          return a;
        if (!a.valid)          return b;
        if (a.prio < b.prio)   return a;
        if (b.prio < a.prio)   return b;
        if (a.idx <= b.idx)    return a;
        return b;
    endfunction

endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
    import arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_sel_i,
    input  logic [IDX_W-1:0]     cfg_chan_i,
    input  logic [CFG_DW-1:0]    cfg_wdata_i,
    output logic [CFG_DW-1:0]    cfg_rdata_o,
    output logic [PRIO_BITS-1:0] prio_o [NUM_CH],
    output logic [NUM_CH-1:0]    en_o,
    output logic [GRP_W-1:0]     group_o
);

    localparam int PAD_W = CFG_DW - PRIO_BITS;

    cfg_sel_e sel;
    logic     chan_ok;

    assign sel     = cfg_sel_e'(cfg_sel_i);
    assign chan_ok = int'(cfg_chan_i) < NUM_CH;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) prio_o[i] <= '0;
            en_o    <= '0;
            group_o <= '0;
        end else if (cfg_we_i) begin
            case (sel)
                SEL_PRIO: if (chan_ok) prio_o[cfg_chan_i] <= cfg_wdata_i[CFG_DW-1 -: PRIO_BITS];
                SEL_EN:   if (chan_ok) en_o[cfg_chan_i]   <= cfg_wdata_i[0];
                SEL_GROUP: begin
                    if (int'(cfg_wdata_i) <= PRIO_BITS) group_o <= cfg_wdata_i[GRP_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata_o = '0;
        case (sel)
            SEL_PRIO:  if (chan_ok) cfg_rdata_o = {prio_o[cfg_chan_i], {PAD_W{1'b0}}};
            SEL_EN:    if (chan_ok) cfg_rdata_o = {{(CFG_DW-1){1'b0}}, en_o[cfg_chan_i]};
            SEL_GROUP: cfg_rdata_o = {{(CFG_DW-GRP_W){1'b0}}, group_o};
            default:   cfg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/arb_pending.sv
module arb_pending
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_i,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  take_idx_i,
    output logic [NUM_CH-1:0] pend_o
);

    logic [NUM_CH-1:0] irq_q;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] clr;

    assign rise = irq_i & ~irq_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
        assign clr[c] = take_i && (int'(take_idx_i) == c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            pend_o <= '0;
        end else begin
            irq_q  <= irq_i;
            pend_o <= (pend_o & ~clr) | rise;
        end
    end

endmodule

// File: rtl/arb_min_tree.sv
module arb_min_tree
    import arb_pkg::*;
(
    input  logic [NUM_CH-1:0]    req_i,
    input  logic [PRIO_BITS-1:0] prio_i [NUM_CH],
    output cand_t                win_o
);

    localparam int NODES = 2 * LEAVES - 1;

    cand_t leaf [LEAVES];
    cand_t node [NODES];

    for (genvar c = 0; c < LEAVES; c++) begin : g_leaf
        if (c < NUM_CH) begin : g_real
            assign leaf[c] = '{valid: req_i[c], prio: prio_i[c], idx: IDX_W'(c)};
        end else begin : g_pad
            assign leaf[c] = '{valid: 1'b0, prio: '0, idx: IDX_W'(c)};
        end
    end

    // Heap-ordered reduction: left subtrees hold the lower channel indices
    always_comb begin
        for (int i = 0; i < LEAVES; i++) node[LEAVES-1+i] = leaf[i];
        for (int i = LEAVES - 2; i >= 0; i--) node[i] = pick(node[2*i+1], node[2*i+2]);
    end

    assign win_o = node[0];

endmodule

// File: rtl/arb_level_stack.sv
module arb_level_stack
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [LVL_W-1:0] act_lvl_o,
    output logic             full_o
);

    localparam int SP_W  = $clog2(STACK_DEPTH + 1);
    localparam int TOP_W = $clog2(STACK_DEPTH);

    logic [LVL_W-1:0] stk [STACK_DEPTH];
    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  sp_m1;
    logic [TOP_W-1:0] top_idx;
    logic [TOP_W-1:0] push_idx;

    assign sp_m1    = sp - 1'b1;
    assign top_idx  = sp_m1[TOP_W-1:0];
    assign push_idx = sp[TOP_W-1:0];
    assign full_o   = (int'(sp) == STACK_DEPTH);
    assign act_lvl_o = (sp == '0) ? LVL_W'(THREAD_LVL) : stk[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= '0;
        end else if (pop_i) begin
            if (sp != '0) sp <= sp_m1;
        end else if (push_i && !full_o) begin
            stk[push_idx] <= push_lvl_i;
            sp            <= sp + 1'b1;
        end
    end

endmodule

// File: rtl/grp_irq_arbiter.sv
module grp_irq_arbiter
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [IDX_W-1:0]  cfg_chan_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    output logic [CFG_DW-1:0] cfg_rdata_o,
    input  logic              eoi_i,
    output logic              take_o,
    output logic [IDX_W-1:0]  vec_o,
    output logic [LVL_W-1:0]  act_lvl_o
);

    logic [PRIO_BITS-1:0] prio  [NUM_CH];
    logic [NUM_CH-1:0]    en;
    logic [GRP_W-1:0]     group;
    logic [NUM_CH-1:0]    pend;
    cand_t                win;
    logic [LVL_W-1:0]     win_pre;
    logic [LVL_W-1:0]     cur_lvl;
    logic                 stk_full;
    logic                 take_now;

    arb_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_we_i    (cfg_we_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_chan_i  (cfg_chan_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o),
        .prio_o      (prio),
        .en_o        (en),
        .group_o     (group)
    );

    arb_pending u_pend (
        .clk        (clk),
        .rst        (rst),
        .irq_i      (irq_i),
        .take_i     (take_now),
        .take_idx_i (win.idx),
        .pend_o     (pend)
    );

    arb_min_tree u_tree (
        .req_i  (pend & en),
        .prio_i (prio),
        .win_o  (win)
    );

    arb_level_stack u_stk (
        .clk        (clk),
        .rst        (rst),
        .push_i     (take_now),
        .push_lvl_i (win_pre),
        .pop_i      (eoi_i),
        .act_lvl_o  (cur_lvl),
        .full_o     (stk_full)
    );

    assign win_pre  = preempt_of(win.prio, group);
    assign take_now = win.valid && (win_pre < cur_lvl) && !eoi_i && !stk_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o <= 1'b0;
            vec_o  <= '0;
        end else begin
            take_o <= take_now;
            if (take_now) vec_o <= win.idx;
        end
    end

    assign act_lvl_o = cur_lvl;

endmodule

// File: rtl/arb_chk.sv
module arb_chk
    import arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              take_o,
    input logic [IDX_W-1:0]  vec_o,
    input logic [LVL_W-1:0]  act_lvl_o,
    input logic              eoi_i,
    input logic [1:0]        cfg_sel_i,
    input logic [CFG_DW-1:0] cfg_rdata_o
);

    p_low_nibble_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel_i == 2'd0) |-> (cfg_rdata_o[CFG_DW-PRIO_BITS-1:0] == '0));

    p_group_range_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel_i == 2'd2) |-> (int'(cfg_rdata_o) <= PRIO_BITS));

    p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (int'(vec_o) < NUM_CH));

    p_take_lowers_r7: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (act_lvl_o < $past(act_lvl_o)));

    p_lvl_range_r8: assert property (@(posedge clk) disable iff (rst)
        int'(act_lvl_o) <= THREAD_LVL);

    p_eoi_restores_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && int'(act_lvl_o) != THREAD_LVL) |=> (act_lvl_o > $past(act_lvl_o)));

    p_eoi_thread_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && int'(act_lvl_o) == THREAD_LVL) |=> (int'(act_lvl_o) == THREAD_LVL && !take_o));

    p_lvl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!take_o && !$past(eoi_i)) |-> (act_lvl_o == $past(act_lvl_o)));

endmodule

bind grp_irq_arbiter arb_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .take_o      (take_o),
    .vec_o       (vec_o),
    .act_lvl_o   (act_lvl_o),
    .eoi_i       (eoi_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_rdata_o (cfg_rdata_o)
);

// File: tb/grp_irq_arbiter_tb.sv
module grp_irq_arbiter_tb;
    import arb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] irq = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd3;
    logic [IDX_W-1:0]  cfg_chan = '0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic              eoi = 1'b0;
    logic              take;
    logic [IDX_W-1:0]  vec;
    logic [LVL_W-1:0]  lvl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    grp_irq_arbiter u_dut (
        .clk(clk), .rst(rst), .irq_i(irq), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_chan_i(cfg_chan), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .eoi_i(eoi), .take_o(take), .vec_o(vec), .act_lvl_o(lvl)
    );

    typedef struct packed {
        logic [2:0] g;
        logic [5:0] ca;
        logic [3:0] pa;
        logic [5:0] cb;
        logic [3:0] pb;
        logic [5:0] ev;
        logic [4:0] el;
    } vec_t;

    // two simultaneous requests from thread level: winner and resulting level
    localparam vec_t VT [7] = '{
        '{3'd2, 6'd3,  4'h5, 6'd10, 4'h4, 6'd10, 5'd1},
        '{3'd2, 6'd3,  4'h4, 6'd10, 4'h4, 6'd3,  5'd1},
        '{3'd0, 6'd7,  4'h9, 6'd2,  4'hA, 6'd7,  5'd0},
        '{3'd4, 6'd20, 4'h3, 6'd59, 4'h2, 6'd59, 5'd2},
        '{3'd1, 6'd0,  4'h8, 6'd1,  4'h7, 6'd1,  5'd0},
        '{3'd3, 6'd30, 4'hF, 6'd31, 4'hF, 6'd30, 5'd7},
        '{3'd4, 6'd33, 4'h6, 6'd12, 4'h6, 6'd12, 5'd6}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; irq = '0; eoi = 1'b0; cfg_we = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input int ch, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_chan = IDX_W'(ch); cfg_wdata = d;
        step();
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic rd(input logic [1:0] s, input int ch, output int d);
        cfg_sel = s; cfg_chan = IDX_W'(ch);
        #1;
        d = int'(cfg_rdata);
        cfg_sel = 2'd3;
    endtask

    task automatic end_handler();
        eoi = 1'b1;
        step();
        eoi = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d;
        // reset state
        do_reset();
        chk("R1 take", int'(take), 0);
        chk("R1 level", int'(lvl), THREAD_LVL);
        rd(2'd0, 5, d);  chk("R1 prio", d, 0);
        rd(2'd1, 5, d);  chk("R1 enable", d, 0);
        rd(2'd2, 0, d);  chk("R1 group", d, 0);

        // low nibble dropped
        wr(2'd0, 5, 8'hAB);
        rd(2'd0, 5, d);  chk("R2 prio readback", d, 8'hA0);

        // grouping bounds
        wr(2'd2, 0, 8'd3);
        rd(2'd2, 0, d);  chk("R3 group set", d, 3);
        wr(2'd2, 0, 8'd7);
        rd(2'd2, 0, d);  chk("R3 group large ignored", d, 3);

        // vector table walk: ordering and preemption value
        for (int k = 0; k < 7; k++) begin
            do_reset();
            wr(2'd2, 0, {5'd0, VT[k].g});
            wr(2'd0, int'(VT[k].ca), {VT[k].pa, 4'hF});
            wr(2'd0, int'(VT[k].cb), {VT[k].pb, 4'h3});
            wr(2'd1, int'(VT[k].ca), 8'd1);
            wr(2'd1, int'(VT[k].cb), 8'd1);
            irq[VT[k].ca] = 1'b1;
            irq[VT[k].cb] = 1'b1;
            step(); step();
            chk("R6 take", int'(take), 1);
            chk("R6 winner", int'(vec), int'(VT[k].ev));
            chk("R3 level", int'(lvl), int'(VT[k].el));
            irq = '0;
        end

        // disabled channel keeps pending, taken when enabled; pulse width
        do_reset();
        irq[4] = 1'b1;
        step(); step(); step();
        chk("R5 disabled no take", int'(take), 0);
        wr(2'd1, 4, 8'd1);
        step();
        chk("R5 take after enable", int'(take), 1);
        chk("R5 vec", int'(vec), 4);
        step();
        chk("R4 one-cycle pulse", int'(take), 0);
        step(); step();
        chk("R4 held line not retaken", int'(take), 0);
        irq = '0;

        // nesting with grouping 2
        do_reset();
        wr(2'd2, 0, 8'd2);
        wr(2'd0, 1, 8'hB0); wr(2'd0, 2, 8'h40); wr(2'd0, 3, 8'h50); wr(2'd0, 4, 8'h80);
        for (int c = 1; c <= 4; c++) wr(2'd1, c, 8'd1);
        irq[1] = 1'b1; step(); step();
        chk("R8 first take", int'(vec), 1);
        chk("R8 level 2", int'(lvl), 2);
        irq[4] = 1'b1; step(); step(); step();
        chk("R7 sub-priority no preempt", int'(take), 0);
        irq[2] = 1'b1; step(); step();
        chk("R7 preempt take", int'(take), 1);
        chk("R7 preempt vec", int'(vec), 2);
        chk("R8 level 1", int'(lvl), 1);
        irq[3] = 1'b1; step(); step(); step();
        chk("R7 equal level waits", int'(take), 0);
        end_handler();
        chk("R8 eoi blocks take", int'(take), 0);
        chk("R8 restore level 2", int'(lvl), 2);
        step();
        chk("R6 waiting winner vec", int'(vec), 3);
        chk("R6 waiting winner take", int'(take), 1);
        end_handler();
        chk("R8 back to 2", int'(lvl), 2);
        step();
        chk("R7 equal still waits", int'(take), 0);
        end_handler();
        chk("R8 thread", int'(lvl), THREAD_LVL);
        step();
        chk("R8 last pending taken", int'(vec), 4);
        chk("R8 last level", int'(lvl), 2);
        end_handler();
        end_handler();
        chk("R8 eoi at thread", int'(lvl), THREAD_LVL);
        irq = '0;

        // full-depth nesting with grouping 4
        do_reset();
        wr(2'd2, 0, 8'd4);
        for (int v = 0; v < 16; v++) begin
            wr(2'd0, 40 + v, {4'(v), 4'h0});
            wr(2'd1, 40 + v, 8'd1);
        end
        for (int v = 15; v >= 0; v--) begin
            irq[40 + v] = 1'b1;
            step(); step();
            chk("R7 deep take", int'(take), 1);
            chk("R8 deep level", int'(lvl), v);
        end
        for (int v = 1; v <= 16; v++) begin
            end_handler();
            chk("R8 deep unwind", int'(lvl), v);
        end
        irq = '0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule